// File: doc/BRIEF.md
# Center-Aligned Half-Step PWM Generator

The block drives one switch-control pin with a symmetric pulse train. A time base steps up from zero to the period value and back down again, without stopping, so one PWM frame lasts twice the period value in clock cycles. The pulse widens and narrows around the frame's zero point. The output is active-low, which suits a high-side P-channel switch that conducts while its gate is pulled low.

The duty value is compared at half-step resolution. Each of the two clock cycles that share a time-base level gets its own fine position, so the duty value counts on-cycles directly and runs from 0 to twice the period. A period of 25 therefore gives 51 duty settings, roughly 100 mV per step on a 5 V swing after filtering. Duty and period are taken from their inputs only at the frame's zero point. At that same point a one-cycle request strobe tells an upstream sample source, such as a waveform table walker, to present the next duty value. A synchronous enable stops the frame and parks the pin high.

Top module: `cpwm_center`

## Requirements
- R1: While reset is asserted, `pwm_n` is 1 and `sample_req` is 0. The reset is asynchronous assert and synchronous release; outputs keep their reset values for two edges after release.
- R2: While enabled, `sample_req` is high for exactly one cycle per frame. A frame lasts 2*P enabled cycles, where P is the latched period. The first enabled cycle after reset or after a disable is a frame start.
- R3: Over one complete frame, `pwm_n` is low for exactly min(D, 2*P) cycles, where D is the duty latched at that frame's start.
- R4: A latched duty of 0 keeps `pwm_n` high for the whole frame.
- R5: A latched duty of 2*P or more keeps `pwm_n` low for the whole frame, with no high cycle at the frame boundary.
- R6: `duty_in` and `period_in` are sampled only on the frame-start cycle. Changes at any other time have no effect on the current frame.
- R7: On the first clock edge with `en` low, `pwm_n` goes high and `sample_req` goes low. The time base returns to its frame start, so re-enabling begins a new frame at once.
- R8: Number the cycles of a frame k = 0 .. 2P-1. Cycle k has fine position 2k for k < P and 4P-2k-1 otherwise. `pwm_n` is low (0) in cycle k exactly when that fine position is below D. `sample_req` and cycle 0 appear together.
- R9: A `period_in` of 0 is latched as a period of 1, giving 2-cycle frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Synchronous run enable; low parks the pin high |
| period_in | input | PER_W | Half-frame length P in clocks, taken at frame start |
| duty_in | input | PER_W+1 | On-cycles per frame D, taken at frame start |
| pwm_n | output | 1 | Active-low switch drive |
| sample_req | output | 1 | One-cycle strobe at each frame start |

## Verification
The bench pushes the duty to both ends of its range. A compare that is off by one would show a one-cycle sliver at zero duty, or a one-cycle high glitch at the frame edge when the duty equals or exceeds twice the period. It changes duty and period in the middle of frames: a design without the shadow latch would reshape a frame already in progress and break the per-frame on-time count. It also tests odd duty values, where half-step resolution matters and a whole-step compare would round the on-time to an even number. The remaining cases are a zero period, which a naive counter would wrap on, and disabling part-way through a frame, where a design that failed to rewind its time base would miss the strobe on re-enable.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic {
    SWEEP_UP   = 1'b0,
    SWEEP_DOWN = 1'b1
  } sweep_e;
endpackage

// File: rtl/cpwm_shadow.sv
module cpwm_shadow #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             en,
  input  logic             at_zero,
  input  logic [PER_W-1:0] period_in,
  input  logic [PER_W:0]   duty_in,
  output logic [PER_W-1:0] per_use,
  output logic [PER_W:0]   duty_use,
  output logic [PER_W-1:0] per_q,
  output logic [PER_W:0]   duty_q
);
  logic [PER_W-1:0] per_clean;
  logic             load;

  always_comb begin
    per_clean = (period_in == '0) ? PER_W'(1) : period_in;
    load      = en && at_zero;
    per_use   = at_zero ? per_clean : per_q;
    duty_use  = at_zero ? duty_in   : duty_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      per_q  <= PER_W'(1);
      duty_q <= '0;
    end else if (load) begin
      per_q  <= per_clean;
      duty_q <= duty_in;
    end
  end
endmodule

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
  import cpwm_pkg::*;
#(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             en,
  input  logic [PER_W-1:0] per_use,
  output logic             at_zero,
  output logic [PER_W:0]   fine,
  output logic [PER_W-1:0] level
);
  localparam int FW = PER_W + 1;

  sweep_e           dir_q, dir_d;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] top_m1;

  always_comb begin
    top_m1  = per_use - PER_W'(1);
    at_zero = (cnt_q == '0) && (dir_q == SWEEP_UP);
    fine    = (dir_q == SWEEP_DOWN) ? ({cnt_q, 1'b0} - FW'(1)) : {cnt_q, 1'b0};
    level   = cnt_q;
    cnt_d   = cnt_q;
    dir_d   = dir_q;
    if (!en) begin
      cnt_d = '0;
      dir_d = SWEEP_UP;
    end else if (dir_q == SWEEP_UP) begin
      if (cnt_q == top_m1) begin
        cnt_d = per_use;
        dir_d = SWEEP_DOWN;
      end else begin
        cnt_d = cnt_q + PER_W'(1);
      end
    end else begin
      if (cnt_q == PER_W'(1)) begin
        cnt_d = '0;
        dir_d = SWEEP_UP;
      end else begin
        cnt_d = cnt_q - PER_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
      dir_q <= SWEEP_UP;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end
endmodule

// File: rtl/cpwm_compare.sv
module cpwm_compare #(
  parameter int PER_W = 8
) (
  input  logic           clk,
  input  logic           arst_n,
  input  logic           en,
  input  logic           at_zero,
  input  logic [PER_W:0] fine,
  input  logic [PER_W:0] duty_use,
  output logic           pwm_n,
  output logic           strobe
);
  logic pwm_d, strobe_d;

  always_comb begin
    pwm_d    = en ? !(fine < duty_use) : 1'b1;
    strobe_d = en && at_zero;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pwm_n  <= 1'b1;
      strobe <= 1'b0;
    end else begin
      pwm_n  <= pwm_d;
      strobe <= strobe_d;
    end
  end
endmodule

// File: rtl/cpwm_center.sv
module cpwm_center #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PER_W-1:0] period_in,
  input  logic [PER_W:0]   duty_in,
  output logic             pwm_n,
  output logic             sample_req
);
  logic [1:0]       rst_pipe;
  logic             arst_n;
  logic             at_zero;
  logic [PER_W:0]   fine;
  logic [PER_W-1:0] level;
  logic [PER_W-1:0] per_use, per_q;
  logic [PER_W:0]   duty_use, duty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign arst_n = rst_pipe[1];

  cpwm_shadow #(.PER_W(PER_W)) u_shadow (
    .clk(clk), .arst_n(arst_n), .en(en), .at_zero(at_zero),
    .period_in(period_in), .duty_in(duty_in),
    .per_use(per_use), .duty_use(duty_use),
    .per_q(per_q), .duty_q(duty_q)
  );

  cpwm_timebase #(.PER_W(PER_W)) u_tbase (
    .clk(clk), .arst_n(arst_n), .en(en), .per_use(per_use),
    .at_zero(at_zero), .fine(fine), .level(level)
  );

  cpwm_compare #(.PER_W(PER_W)) u_cmp (
    .clk(clk), .arst_n(arst_n), .en(en), .at_zero(at_zero),
    .fine(fine), .duty_use(duty_use),
    .pwm_n(pwm_n), .strobe(sample_req)
  );
endmodule

// File: rtl/cpwm_center_chk.sv
module cpwm_center_chk #(
  parameter int PER_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             pwm_n,
  input logic             sample_req,
  input logic [PER_W-1:0] per_q,
  input logic [PER_W:0]   duty_q,
  input logic [PER_W-1:0] level
);
  logic en_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_d <= 1'b0;
    else        en_d <= en;
  end

  // R7
  park_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pwm_n && !sample_req));

  // R2
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_req |=> !sample_req);

  // R8
  frame_start_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_req |-> (pwm_n == (duty_q == '0)));

  // R4
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == '0) |-> pwm_n);

  // R5
  full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_d && (duty_q >= {per_q, 1'b0})) |-> !pwm_n);

  // R9
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q != '0) && (level <= per_q));
endmodule

bind cpwm_center cpwm_center_chk #(.PER_W(PER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pwm_n(pwm_n), .sample_req(sample_req),
  .per_q(per_q), .duty_q(duty_q), .level(level)
);

// File: tb/cpwm_center_test.sv
module cpwm_center_test;
  localparam int PER_W = 8;

  logic             clk;
  logic             rst_n;
  logic             en;
  logic [PER_W-1:0] period_in;
  logic [PER_W:0]   duty_in;
  logic             pwm_n;
  logic             sample_req;

  int n_vec;
  int n_bad;
  int cyc;
  bit done;
  string tag;

  int m_pos, m_per, m_duty;
  bit e_pwm, e_str, e_en;
  int act_low, win_d, win_p;
  bit win_valid;

  cpwm_center #(.PER_W(PER_W)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .period_in(period_in),
    .duty_in(duty_in), .pwm_n(pwm_n), .sample_req(sample_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int fine_of(int k, int p);
    return (k < p) ? 2 * k : 4 * p - 2 * k - 1;
  endfunction

  function automatic int on_cycles(int d, int p);
    return (d < 2 * p) ? d : 2 * p;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    e_en = en;
    if (!en) begin
      e_pwm = 1'b1; e_str = 1'b0; m_pos = 0;
    end else begin
      if (m_pos == 0) begin
        m_per  = (period_in == 0) ? 1 : int'(period_in);
        m_duty = int'(duty_in);
        e_str  = 1'b1;
      end else begin
        e_str = 1'b0;
      end
      e_pwm = !(fine_of(m_pos, m_per) < m_duty);
      m_pos = (m_pos + 1 == 2 * m_per) ? 0 : m_pos + 1;
    end
  endtask

  task automatic tick();
    string ptag;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (!e_en)                    ptag = tag;
    else if (m_duty == 0)         ptag = "R4";
    else if (m_duty >= 2 * m_per) ptag = "R5";
    else                          ptag = tag;
    check(ptag, "pwm_n", int'(pwm_n), int'(e_pwm));
    check("R2", "sample_req", int'(sample_req), int'(e_str));
    if (!e_en) begin
      win_valid = 1'b0;
    end else begin
      if (e_str) begin
        if (win_valid) check("R3", "low cycles per frame", act_low, on_cycles(win_d, win_p));
        act_low = 0; win_valid = 1'b1; win_d = m_duty; win_p = m_per;
      end
      if (!pwm_n) act_low++;
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !done) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    n_vec = 0; n_bad = 0; done = 1'b0;
    m_pos = 0; m_per = 1; m_duty = 0; act_low = 0; win_valid = 1'b0;
    win_d = 0; win_p = 1;
    rst_n = 1'b0; en = 1'b0; period_in = '0; duty_in = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1", "pwm_n in reset", int'(pwm_n), 1);
      check("R1", "sample_req in reset", int'(sample_req), 0);
    end
    rst_n = 1'b1;
    tag = "R7";
    run(4);

    tag = "R4"; period_in = 8'd5; duty_in = 9'd0; en = 1'b1;
    run(30);
    tag = "R5"; duty_in = 9'd10;
    run(30);
    duty_in = 9'd13;
    run(20);
    tag = "R8"; duty_in = 9'd7;
    run(30);
    duty_in = 9'd1;
    run(20);

    tag = "R9"; period_in = 8'd0; duty_in = 9'd1;
    run(12);
    duty_in = 9'd2;
    run(8);

    tag = "R6"; period_in = 8'd6; duty_in = 9'd3;
    for (int i = 0; i < 30; i++) begin
      run(5);
      period_in = PER_W'(1 + $urandom_range(0, 9));
      duty_in   = (PER_W+1)'($urandom_range(0, 2 * int'(period_in) + 2));
    end

    tag = "R7"; period_in = 8'd7; duty_in = 9'd9;
    for (int i = 0; i < 6; i++) begin
      en = 1'b1;
      run(3 + $urandom_range(0, 15));
      en = 1'b0;
      run(1 + $urandom_range(0, 3));
    end
    en = 1'b1;

    tag = "R8";
    for (int s = 0; s < 60; s++) begin
      period_in = PER_W'(1 + $urandom_range(0, 11));
      duty_in   = (PER_W+1)'($urandom_range(0, 2 * int'(period_in) + 2));
      en = ($urandom_range(0, 7) != 0);
      run(1 + $urandom_range(0, 40));
    end
    en = 1'b1;
    run(40);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule